// File: doc/BRIEF.md
# Per-Block Character Occurrence Counter

This block watches a bit-serial character stream and tallies how often one chosen character value appears within each fixed-size block of characters. Each character is `CHAR_W` bits wide (default 8) and is sent most-significant bit first. The character counted is set by the `TARGET` parameter, which defaults to 0x40, the ASCII code for '@'. A block is `BLOCK_CHARS` characters long (default 256, and it must be a power of two). A match is tested only when the last bit of a character arrives. The running tally for the current block is always visible on an output. When a block closes, its final tally is captured in a holding register and announced by a one-cycle pulse.

Inside, three small machines share the clock. The first is a recognizer: it holds a bit-position counter and a shift window, and at each character boundary it raises a boundary strobe and, when the window equals the target, a match strobe. The second counts characters within the block. The third counts matches; it is advanced by the match strobe and cleared when the block closes.

The input side is a stream qualified by `in_valid`. A bit is taken on every cycle where `in_valid` is high, and idle cycles are allowed anywhere, including inside a character. The block never stalls, so it has no ready signal and applies no back-pressure: a producer may present a bit whenever it has one. The block-end outputs need no handshake, because each captured total stays in place for at least a whole block.

Top module: `char_occ_counter`

## Requirements
- R1: After reset, `occ_count`, `blk_done`, `blk_total` and `blk_all_hit` are all 0. The first bit accepted after reset is bit position 0, the most significant bit of the first character.
- R2: A character is matched only at character-aligned instants, that is, on the accepted bit whose position within the character is `CHAR_W-1`. The eight accepted bits ending there, with the earliest as the MSB, must equal `TARGET` (0x40). A target pattern that straddles two characters is never counted.
- R3: A cycle with `in_valid` low has no effect. The bit position, the window, `occ_count` and the captured outputs all keep their values, and `blk_done` stays 0.
- R4: In the cycle after the final bit of a matching character is accepted, `occ_count` has risen by exactly one. It does not change on any other accepted bit, except at a block end.
- R5: When the final bit of character number `BLOCK_CHARS` of a block is accepted, `blk_done` is 1 for exactly the next cycle. In that same cycle `blk_total` shows the block's match count, and that count includes a match on the block's final character.
- R6: At a block end `occ_count` returns to 0, so the next block's tally starts from zero.
- R7: The tally saturates at `BLOCK_CHARS-1` (255). If every character of a block matches, `blk_total` is 255 and `blk_all_hit` is 1.
- R8: For any block with fewer matches than characters, `blk_all_hit` is 0. `blk_total` and `blk_all_hit` hold their values until the next block end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A serial bit is present this cycle |
| in_bit | input | 1 | Serial data bit, MSB of each character first |
| occ_count | output | 8 | Running match count for the current block |
| blk_done | output | 1 | One-cycle pulse after a block closes |
| blk_total | output | 8 | Captured match count of the last closed block |
| blk_all_hit | output | 1 | Last closed block matched on every character |

## Verification
The hardest state to reach is a block in which every one of the 256 characters matches. Only that case drives the tally into saturation and sets the all-match flag, and it only happens at the very last bit of 2048 accepted bits. The bench sends a full block of target characters and checks the tally after 255 characters, before the final one; it then checks the captured total and the flag. Straddling patterns are produced by alternating characters whose boundary nibbles spell the target. A sweep of all 256 character values, with idle cycles placed inside characters, covers the alignment rule and the stream qualifier.

// File: rtl/char_occ_pkg.sv
package char_occ_pkg;
  localparam int CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;
  localparam char_t AT_CODE = 8'h40;
endpackage

// File: rtl/char_recognizer.sv
module char_recognizer
  import char_occ_pkg::*;
#(
  parameter char_t TARGET = AT_CODE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic char_end,
  output logic char_hit
);
  localparam int PH_W = $clog2(CHAR_W);
  localparam logic [PH_W-1:0] LAST_POS = PH_W'(CHAR_W - 1);

  logic [PH_W-1:0]   phase_q;
  logic [CHAR_W-2:0] window_q;
  char_t             cand;

  // newest bit enters as the least significant bit
  assign cand     = {window_q, in_bit};
  assign char_end = in_valid && (phase_q == LAST_POS);
  assign char_hit = char_end && (cand == TARGET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= '0;
      window_q <= '0;
    end else if (in_valid) begin
      window_q <= cand[CHAR_W-2:0];
      phase_q  <= (phase_q == LAST_POS) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/block_counter.sv
module block_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic char_end,
  output logic block_end
);
  localparam logic [CNT_W-1:0] LAST_CHAR = {CNT_W{1'b1}};

  logic [CNT_W-1:0] chars_q;

  assign block_end = char_end && (chars_q == LAST_CHAR);

  always_ff @(posedge clk) begin
    if (!rst_n)        chars_q <= '0;
    else if (char_end) chars_q <= chars_q + 1'b1;
  end
endmodule

// File: rtl/hit_counter.sv
module hit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             char_hit,
  input  logic             block_end,
  output logic [CNT_W-1:0] occ_count,
  output logic             blk_done,
  output logic [CNT_W-1:0] blk_total,
  output logic             blk_all_hit
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] occ_q;
  logic             at_ceil;
  logic [CNT_W-1:0] occ_inc;
  logic [CNT_W-1:0] closing;

  assign at_ceil = (occ_q == CEIL);
  assign occ_inc = at_ceil ? occ_q : occ_q + 1'b1;
  assign closing = char_hit ? occ_inc : occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q       <= '0;
      blk_done    <= 1'b0;
      blk_total   <= '0;
      blk_all_hit <= 1'b0;
    end else begin
      blk_done <= 1'b0;
      if (block_end) begin
        blk_total   <= closing;
        // ceiling reached over all earlier characters plus a final match
        blk_all_hit <= char_hit && at_ceil;
        blk_done    <= 1'b1;
        occ_q       <= '0;
      end else if (char_hit) begin
        occ_q <= occ_inc;
      end
    end
  end

  assign occ_count = occ_q;
endmodule

// File: rtl/char_occ_counter.sv
module char_occ_counter
  import char_occ_pkg::*;
#(
  parameter int    BLOCK_CHARS = 256,
  parameter char_t TARGET      = AT_CODE,
  localparam int   CNT_W       = $clog2(BLOCK_CHARS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic [CNT_W-1:0] occ_count,
  output logic             blk_done,
  output logic [CNT_W-1:0] blk_total,
  output logic             blk_all_hit
);
  logic char_end;
  logic char_hit;
  logic block_end;

  generate
    if ((1 << CNT_W) != BLOCK_CHARS) begin : g_bad_size
      initial $error("BLOCK_CHARS must be a power of two");
    end
  endgenerate

  char_recognizer #(.TARGET(TARGET)) u_recog (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .char_end (char_end),
    .char_hit (char_hit)
  );

  block_counter #(.CNT_W(CNT_W)) u_blocks (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_end  (char_end),
    .block_end (block_end)
  );

  hit_counter #(.CNT_W(CNT_W)) u_hits (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_hit    (char_hit),
    .block_end   (block_end),
    .occ_count   (occ_count),
    .blk_done    (blk_done),
    .blk_total   (blk_total),
    .blk_all_hit (blk_all_hit)
  );
endmodule

// File: rtl/char_occ_counter_checker.sv
module char_occ_counter_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [CNT_W-1:0] occ_count,
  input logic             blk_done,
  input logic [CNT_W-1:0] blk_total,
  input logic             blk_all_hit
);
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(occ_count) && !blk_done));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_count != $past(occ_count)) |-> (blk_done || occ_count == CNT_W'($past(occ_count) + 1'b1)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (occ_count == '0));

  assert_all_hit_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && blk_all_hit) |-> (blk_total == {CNT_W{1'b1}}));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |-> ($stable(blk_total) && $stable(blk_all_hit)));
endmodule

bind char_occ_counter char_occ_counter_checker #(.CNT_W(CNT_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .occ_count   (occ_count),
  .blk_done    (blk_done),
  .blk_total   (blk_total),
  .blk_all_hit (blk_all_hit)
);

// File: tb/char_occ_counter_bench.sv
`timescale 1ns/1ps
module char_occ_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic [7:0] occ_count;
  logic       blk_done;
  logic [7:0] blk_total;
  logic       blk_all_hit;

  int checks = 0;
  int errors = 0;
  int exp_hits = 0;
  int exp_chars = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  char_occ_counter u_char_occ_counter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .occ_count(occ_count), .blk_done(blk_done),
    .blk_total(blk_total), .blk_all_hit(blk_all_hit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit b);
    in_valid = v;
    in_bit = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    rst_n = 1'b1;
    exp_hits = 0;
    exp_chars = 0;
  endtask

  task automatic send_char(input logic [7:0] c, input bit gaps);
    for (int i = 7; i >= 0; i--) begin
      if (gaps && (i == 5 || i == 2)) begin
        step(1'b0, ~c[i]);
        // R3: idle cycle leaves the tally and pulse untouched
        check(occ_count == 8'(exp_hits) && !blk_done, "R3", occ_count, exp_hits);
      end
      step(1'b1, c[i]);
      if (i != 0) check(!blk_done, "R5", blk_done, 0);
    end
    exp_chars++;
    if (c == 8'h40) exp_hits++;
    if (exp_chars == 256) begin
      check(blk_done, "R5", blk_done, 1);
      check(blk_total == 8'((exp_hits > 255) ? 255 : exp_hits), "R5", blk_total, exp_hits);
      check(blk_all_hit == (exp_hits == 256), "R7", blk_all_hit, exp_hits == 256);
      check(occ_count == 8'd0, "R6", occ_count, 0);
      exp_chars = 0;
      exp_hits = 0;
    end else begin
      check(!blk_done, "R5", blk_done, 0);
      check(occ_count == 8'(exp_hits), "R4", occ_count, exp_hits);
    end
  endtask

  initial begin
    do_reset();
    check(occ_count == 0 && !blk_done && blk_total == 0 && !blk_all_hit, "R1", occ_count, 0);

    // Sweep all codes; one match per block
    for (int c = 0; c < 256; c++) send_char(8'(c), (c % 16) == 3);
    check(blk_total == 8'd1 && !blk_all_hit, "R8", blk_total, 1);

    // Every character matches: saturation and all-match flag
    for (int c = 0; c < 256; c++) begin
      send_char(8'h40, 1'b0);
      if (c == 254) check(occ_count == 8'd255, "R7", occ_count, 255);
    end
    check(blk_total == 8'd255 && blk_all_hit, "R7", blk_total, 255);

    // Straddling target patterns (0x04 then 0x00) and a match on the final char
    for (int c = 0; c < 256; c++) begin
      if (c % 7 == 0 || c == 255) send_char(8'h40, 1'b0);
      else send_char((c % 2) ? 8'h04 : 8'h00, 1'b0);
    end
    check(blk_total == 8'd38 && !blk_all_hit, "R2", blk_total, 38);

    // Held totals across a partial block, then reset mid-block
    send_char(8'h40, 1'b1);
    send_char(8'h02, 1'b0);
    check(blk_total == 8'd38 && !blk_all_hit, "R8", blk_total, 38);
    in_valid = 1'b1; in_bit = 1'b1;
    step(1'b1, 1'b0);
    do_reset();
    check(occ_count == 0 && blk_total == 0 && !blk_all_hit, "R1", occ_count, 0);
    send_char(8'h40, 1'b0);
    check(occ_count == 8'd1, "R1", occ_count, 1);
    send_char(8'h20, 1'b0);
    send_char(8'h80, 1'b0);
    check(occ_count == 8'd1, "R2", occ_count, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule